// File: doc/BRIEF.md
# Overmodulation Zone Classifier with Fitted Index and Holding Angle

This block sits in the front end of a three-level space-vector modulator. It receives a modulation index and a reference angle that has already been folded into one 60-degree sector. The modulation index is the reference amplitude divided by two thirds of the DC-bus voltage. Each accepted sample passes through a three-stage fixed-point pipeline. The block reports which of three operating zones the sample falls in: the linear zone, a first overmodulation zone, or a second overmodulation zone.

The zone decides what the single quadratic evaluator computes. In the linear zone the index passes through unchanged. In the first overmodulation zone, a three-piece quadratic fit gives the enlarged index that restores the lost fundamental voltage. In the second overmodulation zone, a three-piece linear fit gives the holding angle. The block then decides whether the reference angle lies close enough to either sector edge that the nearest large vector must be held at full length. If so, it reports which edge that vector belongs to.

Indices above the top of the second zone are clamped to that ceiling and flagged. Vector correction by trigonometry, sector folding and dwell-time generation are done by other blocks.

Top module: `om_zone_fitter`

## Requirements
- R1: `zone` codes are 0 for linear (index ≤ 908067, i.e. 0.866 in Q4.20), 1 for the first overmodulation zone (above that and ≤ 953156, i.e. 0.909), and 2 above 953156. Each boundary code belongs to the lower zone. Code 3 never appears.
- R2: In the linear zone, `fitValue` equals the (clamped) input index bit for bit.
- R3: In zone 1, `fitValue` is within 1e-4 of the enlarged-index fit. Below or at 0.897 (code 940573) the fit is 29.855·m² − 50.9·m + 23. Above that and up to 0.905 (code 948961) it is 126.5·m² − 224.233·m + 100.3. Above 0.905 it is 1029·m² − 1859·m + 841.
- R4: In zone 2, `fitValue` is within 1e-4 of the holding angle in radians. Up to 0.936 (code 981467) the angle is 6.702·m − 6.09. Above that and up to 0.953 (code 999293) it is 12.305·m − 11.34. Above 0.953 it is 51.27·m − 48.43.
- R5: `holdActive` is 1 exactly when the zone is 2 and either θ ≤ αh or θ ≥ π/3 − αh. Here αh is the fitted holding angle and π/3 is the code 1098066. Outside zone 2 it is 0.
- R6: `holdEdge` is 1 when holding and θ is above π/6 (code 549033), which selects the large vector at the far sector edge. It is 0 when holding at or below π/6, and 0 whenever `holdActive` is 0.
- R7: An index above 955/1000 (code 1001390) is replaced by 1001390, reported in zone 2, and raises `saturated`. A negative index is treated as zero: linear zone, `fitValue` 0, `saturated` 0.
- R8: `outValid` pulses high three clock edges after the edge that samples `inValid`, once per accepted sample. A new sample may be accepted every cycle. Results stay on the outputs until the next result replaces them.
- R9: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample strobe for miIn and thetaIn |
| miIn | input | 24 | Modulation index, signed Q4.20 |
| thetaIn | input | 24 | Folded sector angle in radians, signed Q4.20, 0 to π/3 |
| outValid | output | 1 | Result strobe, three cycles after inValid |
| zone | output | 2 | 0 linear, 1 first overmodulation, 2 second overmodulation |
| saturated | output | 1 | Index was above the ceiling and was clamped |
| fitValue | output | 24 | Passed index, enlarged index or holding angle, signed Q4.20 |
| holdActive | output | 1 | Angle lies in the holding band |
| holdEdge | output | 1 | Held large vector is at the far sector edge |

## Verification
The hardest case to reach from the ports is where the holding-band comparison and the segment boundaries meet. There, the fitted holding angle at an exact threshold code decides whether an angle sitting at the band edge, at π/6, or at π/3 is held, and which edge it is held to. The stimulus first places the index exactly on every threshold code and one code either side of it, each combined with angles of 0, π/6 and π/3. It then runs a dense index sweep crossed with angles spread across the sector. Only samples whose angle lies within a few millionths of a radian of a band edge are excused from the hold comparison.

// File: rtl/omfit_pkg.sv
package omfit_pkg;

  localparam int DATA_W = 24;
  localparam int FRAC_W = 20;
  localparam int COEF_W = 32;
  localparam int SQ_W   = 2 * DATA_W;
  localparam int LIN_W  = COEF_W + DATA_W;
  localparam int ACC_W  = COEF_W + SQ_W + 2;

  // zone and segment thresholds in Q4.20 (inclusive upper bounds)
  localparam logic signed [DATA_W-1:0] MI_LIN_TOP = 24'sd908067;   // 0.866
  localparam logic signed [DATA_W-1:0] MI_OM1_K1  = 24'sd940573;   // 0.897
  localparam logic signed [DATA_W-1:0] MI_OM1_K2  = 24'sd948961;   // 0.905
  localparam logic signed [DATA_W-1:0] MI_OM1_TOP = 24'sd953156;   // 0.909
  localparam logic signed [DATA_W-1:0] MI_OM2_K1  = 24'sd981467;   // 0.936
  localparam logic signed [DATA_W-1:0] MI_OM2_K2  = 24'sd999293;   // 0.953
  localparam logic signed [DATA_W-1:0] MI_CEIL    = 24'sd1001390;  // 0.955
  localparam logic signed [DATA_W-1:0] ANG_THIRD  = 24'sd1098066;  // pi/3
  localparam logic signed [DATA_W-1:0] ANG_SIXTH  = 24'sd549033;   // pi/6

  typedef enum logic [1:0] {
    ZONE_LIN = 2'd0,
    ZONE_OM1 = 2'd1,
    ZONE_OM2 = 2'd2
  } zone_e;

  typedef enum logic [2:0] {
    SEG_LIN   = 3'd0,
    SEG_OM1_A = 3'd1,
    SEG_OM1_B = 3'd2,
    SEG_OM1_C = 3'd3,
    SEG_OM2_A = 3'd4,
    SEG_OM2_B = 3'd5,
    SEG_OM2_C = 3'd6
  } segSel_t;

  typedef struct packed {
    logic signed [COEF_W-1:0] a;  // square term
    logic signed [COEF_W-1:0] b;  // linear term
    logic signed [COEF_W-1:0] c;  // constant
  } coefSet_t;

  typedef struct packed {
    logic    loadS1;
    logic    loadS2;
    logic    loadS3;
    segSel_t seg;        // aligned with stage-1 registers
    logic    holdCheck;  // aligned with stage-2 registers
  } ctrlStrobes_t;

  // coefficients in Q.20 held in COEF_W-bit signed words
  function automatic coefSet_t coefFor(segSel_t s);
    coefSet_t r;
    r = '0;
    case (s)
      SEG_LIN:   r.b = 32'sd1048576;
      SEG_OM1_A: begin r.a = 32'sd31305236;   r.b = -32'sd53372518;   r.c = 32'sd24117248;  end
      SEG_OM1_B: begin r.a = 32'sd132644864;  r.b = -32'sd235125342;  r.c = 32'sd105172173; end
      SEG_OM1_C: begin r.a = 32'sd1078984704; r.b = -32'sd1949302784; r.c = 32'sd881852416; end
      SEG_OM2_A: begin r.b = 32'sd7027556;    r.c = -32'sd6385828;  end
      SEG_OM2_B: begin r.b = 32'sd12902728;   r.c = -32'sd11890852; end
      SEG_OM2_C: begin r.b = 32'sd53760492;   r.c = -32'sd50782536; end
      default:   r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/omfit_ctrl.sv
module omfit_ctrl
  import omfit_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] miIn,
  output ctrlStrobes_t             strb,
  output logic                     outValid,
  output logic [1:0]               zoneOut,
  output logic                     satOut
);

  logic    isNeg;
  logic    isOver;
  zone_e   zoneNow;
  segSel_t segNow;

  // classification on the raw index; negative counts as zero
  always_comb begin
    isNeg  = miIn[DATA_W-1];
    isOver = !isNeg && (miIn > MI_CEIL);
    if (isNeg || (miIn <= MI_LIN_TOP)) begin
      zoneNow = ZONE_LIN;
      segNow  = SEG_LIN;
    end else if (miIn <= MI_OM1_TOP) begin
      zoneNow = ZONE_OM1;
      if (miIn <= MI_OM1_K1)      segNow = SEG_OM1_A;
      else if (miIn <= MI_OM1_K2) segNow = SEG_OM1_B;
      else                        segNow = SEG_OM1_C;
    end else begin
      zoneNow = ZONE_OM2;
      if (isOver || (miIn > MI_OM2_K2)) segNow = SEG_OM2_C;
      else if (miIn <= MI_OM2_K1)       segNow = SEG_OM2_A;
      else                              segNow = SEG_OM2_B;
    end
  end

  logic    validS1, validS2;
  zone_e   zoneS1, zoneS2;
  logic    satS1, satS2;
  segSel_t segS1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validS1  <= 1'b0;
      validS2  <= 1'b0;
      outValid <= 1'b0;
      zoneS1   <= ZONE_LIN;
      zoneS2   <= ZONE_LIN;
      zoneOut  <= 2'd0;
      satS1    <= 1'b0;
      satS2    <= 1'b0;
      satOut   <= 1'b0;
      segS1    <= SEG_LIN;
    end else begin
      validS1  <= inValid;
      validS2  <= validS1;
      outValid <= validS2;
      if (inValid) begin
        zoneS1 <= zoneNow;
        satS1  <= isOver;
        segS1  <= segNow;
      end
      if (validS1) begin
        zoneS2 <= zoneS1;
        satS2  <= satS1;
      end
      if (validS2) begin
        zoneOut <= zoneS2;
        satOut  <= satS2;
      end
    end
  end

  always_comb begin
    strb.loadS1    = inValid;
    strb.loadS2    = validS1;
    strb.loadS3    = validS2;
    strb.seg       = segS1;
    strb.holdCheck = (zoneS2 == ZONE_OM2);
  end

endmodule

// File: rtl/omfit_datapath.sv
module omfit_datapath
  import omfit_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strb,
  input  logic signed [DATA_W-1:0] miIn,
  input  logic signed [DATA_W-1:0] thetaIn,
  output logic signed [DATA_W-1:0] fitValue,
  output logic                     holdActive,
  output logic                     holdEdge
);

  localparam int RES_SHIFT = 2 * FRAC_W;
  localparam logic signed [ACC_W-1:0] ROUND_HALF =
    {{(ACC_W-1){1'b0}}, 1'b1} << (RES_SHIFT - 1);

  // stage 1: clamp and capture
  logic signed [DATA_W-1:0] miClamp;
  logic signed [DATA_W-1:0] miS1, thS1;

  always_comb begin
    if (miIn[DATA_W-1])      miClamp = '0;
    else if (miIn > MI_CEIL) miClamp = MI_CEIL;
    else                     miClamp = miIn;
  end

  // stage 2: square and linear products
  coefSet_t                 coefS1;
  logic signed [SQ_W-1:0]   sqS2;
  logic signed [LIN_W-1:0]  linS2;
  logic signed [COEF_W-1:0] quadCoefS2, constS2;
  logic signed [DATA_W-1:0] thS2;

  always_comb coefS1 = coefFor(strb.seg);

  // stage 3: accumulate, round, compare
  logic signed [ACC_W-1:0]  accS3;
  logic signed [DATA_W-1:0] fitNext, farLimit;
  logic                     holdNext, edgeNext;

  always_comb begin
    accS3 = ACC_W'(quadCoefS2) * ACC_W'(sqS2)
          + (ACC_W'(linS2) <<< FRAC_W)
          + (ACC_W'(constS2) <<< RES_SHIFT);
    fitNext  = DATA_W'((accS3 + ROUND_HALF) >>> RES_SHIFT);
    farLimit = ANG_THIRD - fitNext;
    holdNext = strb.holdCheck && ((thS2 <= fitNext) || (thS2 >= farLimit));
    edgeNext = holdNext && (thS2 > ANG_SIXTH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      miS1       <= '0;
      thS1       <= '0;
      sqS2       <= '0;
      linS2      <= '0;
      quadCoefS2 <= '0;
      constS2    <= '0;
      thS2       <= '0;
      fitValue   <= '0;
      holdActive <= 1'b0;
      holdEdge   <= 1'b0;
    end else begin
      if (strb.loadS1) begin
        miS1 <= miClamp;
        thS1 <= thetaIn;
      end
      if (strb.loadS2) begin
        sqS2       <= SQ_W'(miS1) * SQ_W'(miS1);
        linS2      <= LIN_W'(coefS1.b) * LIN_W'(miS1);
        quadCoefS2 <= coefS1.a;
        constS2    <= coefS1.c;
        thS2       <= thS1;
      end
      if (strb.loadS3) begin
        fitValue   <= fitNext;
        holdActive <= holdNext;
        holdEdge   <= edgeNext;
      end
    end
  end

endmodule

// File: rtl/om_zone_fitter.sv
module om_zone_fitter
  import omfit_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] miIn,
  input  logic signed [DATA_W-1:0] thetaIn,
  output logic                     outValid,
  output logic [1:0]               zone,
  output logic                     saturated,
  output logic signed [DATA_W-1:0] fitValue,
  output logic                     holdActive,
  output logic                     holdEdge
);

  ctrlStrobes_t strb;

  omfit_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .miIn     (miIn),
    .strb     (strb),
    .outValid (outValid),
    .zoneOut  (zone),
    .satOut   (saturated)
  );

  omfit_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .miIn       (miIn),
    .thetaIn    (thetaIn),
    .fitValue   (fitValue),
    .holdActive (holdActive),
    .holdEdge   (holdEdge)
  );

endmodule

// File: rtl/om_zone_fitter_checker.sv
module om_zone_fitter_checker
  import omfit_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] miIn,
  input logic                     outValid,
  input logic [1:0]               zone,
  input logic                     saturated,
  input logic signed [DATA_W-1:0] fitValue,
  input logic                     holdActive,
  input logic                     holdEdge
);

  logic [2:0]               vPipe;
  logic signed [DATA_W-1:0] miP0, miP1, miP2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe <= '0;
      miP0  <= '0;
      miP1  <= '0;
      miP2  <= '0;
    end else begin
      vPipe <= {vPipe[1:0], inValid};
      miP0  <= miIn;
      miP1  <= miP0;
      miP2  <= miP1;
    end
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    vPipe[2] |-> outValid);
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rstN)
    !vPipe[2] |-> !outValid);
  assert_zone_code_R1: assert property (@(posedge clk) disable iff (!rstN)
    zone != 2'd3);
  assert_linear_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && zone == 2'd0 && !miP2[DATA_W-1]) |-> (fitValue == miP2));
  assert_negative_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && miP2[DATA_W-1]) |-> (zone == 2'd0 && fitValue == '0 && !saturated));
  assert_over_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && miP2 > MI_CEIL) |-> (saturated && zone == 2'd2));
  assert_sat_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    saturated |-> holdActive);
  assert_hold_zone_R5: assert property (@(posedge clk) disable iff (!rstN)
    holdActive |-> (zone == 2'd2));
  assert_edge_needs_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdEdge |-> holdActive);

endmodule

bind om_zone_fitter om_zone_fitter_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .miIn       (miIn),
  .outValid   (outValid),
  .zone       (zone),
  .saturated  (saturated),
  .fitValue   (fitValue),
  .holdActive (holdActive),
  .holdEdge   (holdEdge)
);

// File: tb/om_zone_fitter_tb_top.sv
`timescale 1ns/1ps
module om_zone_fitter_tb_top;

  localparam real SCALE = 1048576.0;
  localparam real PI    = 3.14159265358979;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [23:0] miIn = '0;
  logic signed [23:0] thetaIn = '0;
  logic outValid, saturated, holdActive, holdEdge;
  logic [1:0] zone;
  logic signed [23:0] fitValue;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int tLin, tK1, tK2, tOm1, tH1, tH2, tCeil, p6, p3;

  always #4 clk = ~clk;

  om_zone_fitter dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .miIn(miIn), .thetaIn(thetaIn),
    .outValid(outValid), .zone(zone), .saturated(saturated), .fitValue(fitValue),
    .holdActive(holdActive), .holdEdge(holdEdge)
  );

  function automatic int q20(real x);
    return $rtoi(x * SCALE + 0.5);
  endfunction

  function automatic real absr(real x);
    return (x < 0.0) ? -x : x;
  endfunction

  task automatic check(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%f expected=%f", req, act, exp);
    end
  endtask

  task automatic model(input int code, output int eff, output int zE,
                       output bit sE, output real fE);
    real m;
    eff = (code < 0) ? 0 : ((code > tCeil) ? tCeil : code);
    sE  = (code > tCeil);
    m   = $itor(eff) / SCALE;
    if (eff <= tLin) begin
      zE = 0; fE = m;
    end else if (eff <= tOm1) begin
      zE = 1;
      if (eff <= tK1)      fE = 29.855 * m * m - 50.9 * m + 23.0;
      else if (eff <= tK2) fE = 126.5 * m * m - 224.233 * m + 100.3;
      else                 fE = 1029.0 * m * m - 1859.0 * m + 841.0;
    end else begin
      zE = 2;
      if (eff <= tH1)      fE = 6.702 * m - 6.09;
      else if (eff <= tH2) fE = 12.305 * m - 11.34;
      else                 fE = 51.27 * m - 48.43;
    end
  endtask

  // compare the present outputs with the model for one sample
  task automatic checkOut(input int code, input int th);
    int eff, zE;
    bit sE, hE, eE, amb;
    real fE, fA, thr;
    model(code, eff, zE, sE, fE);
    fA = $itor(fitValue) / SCALE;
    check(outValid === 1'b1, "R8 outValid at result", $itor(outValid), 1.0);
    check(zone === 2'(zE), "R1 zone", $itor(zone), $itor(zE));
    check(saturated === sE, "R7 saturated", $itor(saturated), $itor(sE));
    if (zE == 0)
      check(fitValue === 24'(eff), "R2 linear pass", fA, $itor(eff) / SCALE);
    else if (zE == 1)
      check(absr(fA - fE) <= 1.0e-4, "R3 enlarged index", fA, fE);
    else
      check(absr(fA - fE) <= 1.0e-4, "R4 holding angle", fA, fE);
    hE = 0; amb = 0;
    if (zE == 2) begin
      thr = $itor(th) / SCALE;
      amb = (absr(thr - fE) < 2.0e-5) || (absr(thr - (PI / 3.0 - fE)) < 2.0e-5);
      hE  = (thr <= fE) || (thr >= PI / 3.0 - fE);
    end
    eE = hE && (th > p6);
    if (!amb) begin
      check(holdActive === hE, "R5 hold band", $itor(holdActive), $itor(hE));
      check(holdEdge === eE, "R6 hold edge", $itor(holdEdge), $itor(eE));
    end
  endtask

  task automatic runOne(input int code, input int th);
    @(negedge clk);
    inValid = 1'b1; miIn = 24'(code); thetaIn = 24'(th);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check(outValid === 1'b0, "R8 no early result", $itor(outValid), 0.0);
    @(negedge clk);
    checkOut(code, th);
  endtask

  int burstMi[5];
  int burstTh[5];
  int thList[7];
  int edges[7];

  initial begin
    tLin = q20(0.866); tK1 = q20(0.897); tK2 = q20(0.905); tOm1 = q20(0.909);
    tH1 = q20(0.936); tH2 = q20(0.953); tCeil = q20(0.955);
    p6 = q20(PI / 6.0); p3 = q20(PI / 3.0);

    // R9: reset state
    repeat (3) @(negedge clk);
    check(outValid === 1'b0 && zone === 2'd0 && saturated === 1'b0,
          "R9 reset flags", $itor(zone), 0.0);
    check(fitValue === '0 && holdActive === 1'b0 && holdEdge === 1'b0,
          "R9 reset data", $itor(fitValue), 0.0);
    rstN = 1'b1;

    // R2, R7: linear points, negative and oversize indices
    runOne(0, 0);
    runOne(1, p6);
    runOne(q20(0.3), q20(0.4));
    runOne(-1, p3);
    runOne(-1048576, 0);
    runOne(1048576, p6);
    runOne(8388607, q20(0.2));

    // R1, R3, R4, R5, R6: every threshold and its neighbours
    edges = '{tLin, tK1, tK2, tOm1, tH1, tH2, tCeil};
    foreach (edges[i]) begin
      for (int d = -1; d <= 1; d++) begin
        runOne(edges[i] + d, 0);
        runOne(edges[i] + d, p6);
        runOne(edges[i] + d, p3);
      end
    end

    // dense sweep across all three zones and the sector
    thList = '{0, q20(0.01), q20(0.3), p6, q20(0.75), q20(1.04), p3};
    for (int c = q20(0.80); c <= q20(0.97); c += 512) begin
      for (int k = 0; k < 7; k++) runOne(c, thList[k]);
    end

    // R8: back-to-back samples, one result per cycle
    burstMi = '{tLin, tOm1 + 1, q20(0.96), -5, q20(0.9)};
    burstTh = '{q20(0.1), 0, p6 + 1, p3, q20(0.5)};
    for (int j = 0; j < 9; j++) begin
      @(negedge clk);
      if (j >= 3 && j - 3 < 5) checkOut(burstMi[j-3], burstTh[j-3]);
      else if (j >= 3)
        check(outValid === 1'b0, "R8 burst end", $itor(outValid), 0.0);
      if (j < 5) begin
        inValid = 1'b1; miIn = 24'(burstMi[j]); thetaIn = 24'(burstTh[j]);
      end else begin
        inValid = 1'b0;
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule